// File: doc/BRIEF.md
# Multi-Segment Burst ROM Target

This block is a read-only memory target on a packet-style request/response bus. The bus width is a parameter and may be 32 or 64 bits. The target answers reads in one or more separate address windows. Each window has its own base address and byte size. The contents of each window are fixed when the design is elaborated: every 32-bit word is a function of its own byte address and a seed parameter. Nothing is written at run time.

An initiator sends a read as one command flit. That flit carries a word-aligned start address, a byte length that is a multiple of 4, and three identifiers. The target then returns a burst of data flits. The burst reads consecutive words, starting at the requested address. The last flit is marked as the end of the packet.

On a 64-bit bus, each flit carries two words, with the lower-addressed word in the low half. If the word count is odd, the burst ends with a flit that holds one word in its low half and zeros above it. The target rejects a request with a single error flit in any of these cases:
- the request is a write;
- the request has a zero length;
- the requested range does not lie wholly inside one window.

Top module: `burst_rom_target`

## Requirements
- R1: Elaboration fails unless DATA_W is 32 or 64, ADDR_W exceeds LEN_W, and every segment base and size is a multiple of 4 with a non-zero size.
- R2: After reset, rsp_val is 0 and cmd_ack is 1. cmd_ack is 1 only while no response is pending. A command is taken in a cycle with cmd_val and cmd_ack both high, and the first response flit is valid in the next cycle.
- R3: With DATA_W = 32, a good read returns cmd_plen/4 flits. Flit k carries the word at byte address cmd_addr + 4k.
- R4: With DATA_W = 64 and an even word count, a good read returns cmd_plen/8 flits. Flit k carries the word at cmd_addr + 8k in bits 31:0 and the word at cmd_addr + 8k + 4 in bits 63:32.
- R5: With DATA_W = 64 and an odd word count, a good read returns cmd_plen/8 + 1 flits. The last flit carries its single word in bits 31:0, and bits 63:32 are 0.
- R6: rsp_eop is 1 on the final flit of every response and 0 on every other flit.
- R7: While rsp_val is 1 and rsp_ack is 0, the next cycle still has rsp_val at 1, with rsp_data, rsp_eop, rsp_err and the identifiers unchanged. A flit is consumed only in a cycle where rsp_val and rsp_ack are both 1.
- R8: The response is one flit with rsp_err = 1, rsp_eop = 1 and rsp_data = 0 in any of these cases: the command is a write (cmd_write = 1), cmd_plen is 0, or the byte range [cmd_addr, cmd_addr + cmd_plen) does not lie wholly inside one segment. A range that ends exactly at a segment's end is valid. Good reads have rsp_err = 0.
- R9: Every flit of a response returns the cmd_srcid, cmd_trdid and cmd_pktid of its command on rsp_srcid, rsp_trdid and rsp_pktid.
- R10: The word at byte address A is {A[15:0] ^ ROM_SEED, ~A[15:0]}. The default ROM_SEED is 16'h5A3C.
- R11: Each segment decodes on its own. With defaults, segment 0 covers 0x1000 to 0x103F and segment 1 covers 0x8000 to 0x801F. A read in either segment returns that segment's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_val | input | 1 | Command flit valid |
| cmd_ack | output | 1 | Target ready to take a command |
| cmd_addr | input | ADDR_W | Byte start address, word aligned |
| cmd_plen | input | LEN_W | Burst length in bytes, multiple of 4 |
| cmd_write | input | 1 | Command is a write (always rejected) |
| cmd_srcid | input | SRC_W | Source identifier |
| cmd_trdid | input | TRD_W | Transaction identifier |
| cmd_pktid | input | PKT_W | Packet identifier |
| rsp_val | output | 1 | Response flit valid |
| rsp_ack | input | 1 | Initiator ready for a response flit |
| rsp_data | output | DATA_W | Response data |
| rsp_eop | output | 1 | Final flit of the response |
| rsp_err | output | 1 | Error response flag |
| rsp_srcid | output | SRC_W | Echoed source identifier |
| rsp_trdid | output | TRD_W | Echoed transaction identifier |
| rsp_pktid | output | PKT_W | Echoed packet identifier |

## Verification
The assertions assume that cmd_addr is word aligned, that cmd_plen is a multiple of 4, and that no input is unknown once reset is released. The address decoding and flit counting are defined only under those conditions. rsp_ack may take any value in any cycle; the hold properties are written for a stalled initiator. The stimulus sends only aligned addresses and lengths, and it drops rsp_ack in a repeating pattern so that stalls fall both inside bursts and on final flits.

// File: rtl/burst_rom_pkg.sv
package burst_rom_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BURST = 2'd1,
      ST_ERR   = 2'd2
   } rom_state_t;

   // content of the 32-bit word at byte address a
   function automatic logic [31:0] rom_word(input logic [31:0] a, input logic [15:0] seed);
      return {a[15:0] ^ seed, ~a[15:0]};
   endfunction

endpackage

// File: rtl/rom_seg_decoder.sv
module rom_seg_decoder #(
   parameter int                          ADDR_W    = 32,
   parameter int                          LEN_W     = 8,
   parameter int                          NUM_SEG   = 2,
   parameter int                          IDX_W     = 5,
   parameter logic [NUM_SEG*ADDR_W-1:0]   SEG_BASE  = '0,
   parameter logic [NUM_SEG*ADDR_W-1:0]   SEG_SIZE  = '0,
   parameter logic [NUM_SEG*IDX_W-1:0]    SEG_WBASE = '0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  plen,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);

   logic [ADDR_W:0]  a_ext;
   logic [ADDR_W:0]  end_ext;
   logic [NUM_SEG-1:0] in_seg;
   logic [IDX_W-1:0] seg_idx [NUM_SEG];

   assign a_ext   = {1'b0, addr};
   assign end_ext = a_ext + {{(ADDR_W+1-LEN_W){1'b0}}, plen};

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      localparam logic [ADDR_W-1:0] BASE  = SEG_BASE[s*ADDR_W +: ADDR_W];
      localparam logic [ADDR_W-1:0] SIZE  = SEG_SIZE[s*ADDR_W +: ADDR_W];
      localparam logic [IDX_W-1:0]  WBASE = SEG_WBASE[s*IDX_W +: IDX_W];
      localparam logic [ADDR_W:0]   LO    = {1'b0, BASE};
      localparam logic [ADDR_W:0]   HI    = {1'b0, BASE} + {1'b0, SIZE};
      logic [ADDR_W-1:0] rel;
      assign rel        = addr - BASE;
      assign in_seg[s]  = (a_ext >= LO) && (end_ext <= HI);
      assign seg_idx[s] = WBASE + rel[IDX_W+1:2];
   end

   // lowest-numbered segment wins if windows were ever to overlap
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int s = NUM_SEG - 1; s >= 0; s--) begin
         if (in_seg[s]) begin
            hit = 1'b1;
            idx = seg_idx[s];
         end
      end
   end

endmodule

// File: rtl/rom_image.sv
module rom_image #(
   parameter int                          ADDR_W    = 32,
   parameter int                          NUM_SEG   = 2,
   parameter int                          IDX_W     = 5,
   parameter logic [NUM_SEG*ADDR_W-1:0]   SEG_BASE  = '0,
   parameter logic [NUM_SEG*ADDR_W-1:0]   SEG_SIZE  = '0,
   parameter logic [NUM_SEG*IDX_W-1:0]    SEG_WBASE = '0,
   parameter logic [15:0]                 ROM_SEED  = 16'h5A3C
) (
   input  logic [IDX_W-1:0] idx_a,
   input  logic [IDX_W-1:0] idx_b,
   output logic [31:0]      q_a,
   output logic [31:0]      q_b
);
   import burst_rom_pkg::*;

   localparam int DEPTH = 2 ** IDX_W;

   function automatic logic [DEPTH*32-1:0] build_image();
      logic [DEPTH*32-1:0] img;
      img = '0;
      for (int s = 0; s < NUM_SEG; s++) begin
         logic [ADDR_W-1:0] b;
         int                nw;
         int                wb;
         b  = SEG_BASE[s*ADDR_W +: ADDR_W];
         nw = int'(SEG_SIZE[s*ADDR_W +: ADDR_W]) / 4;
         wb = int'(SEG_WBASE[s*IDX_W +: IDX_W]);
         for (int w = 0; w < nw; w++)
            img[(wb + w)*32 +: 32] = rom_word(32'(b) + 32'(4*w), ROM_SEED);
      end
      return img;
   endfunction

   localparam logic [DEPTH*32-1:0] IMAGE = build_image();

   assign q_a = IMAGE[idx_a*32 +: 32];
   assign q_b = IMAGE[idx_b*32 +: 32];

endmodule

// File: rtl/burst_rom_target.sv
module burst_rom_target #(
   parameter int                          DATA_W   = 64,
   parameter int                          ADDR_W   = 32,
   parameter int                          LEN_W    = 8,
   parameter int                          SRC_W    = 4,
   parameter int                          TRD_W    = 4,
   parameter int                          PKT_W    = 4,
   parameter int                          NUM_SEG  = 2,
   parameter logic [NUM_SEG*ADDR_W-1:0]   SEG_BASE = {32'h0000_8000, 32'h0000_1000},
   parameter logic [NUM_SEG*ADDR_W-1:0]   SEG_SIZE = {32'd32, 32'd64},
   parameter logic [15:0]                 ROM_SEED = 16'h5A3C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_val,
   output logic              cmd_ack,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_plen,
   input  logic              cmd_write,
   input  logic [SRC_W-1:0]  cmd_srcid,
   input  logic [TRD_W-1:0]  cmd_trdid,
   input  logic [PKT_W-1:0]  cmd_pktid,
   output logic              rsp_val,
   input  logic              rsp_ack,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_eop,
   output logic              rsp_err,
   output logic [SRC_W-1:0]  rsp_srcid,
   output logic [TRD_W-1:0]  rsp_trdid,
   output logic [PKT_W-1:0]  rsp_pktid
);
   import burst_rom_pkg::*;

   localparam int WPF = DATA_W / 32;

   function automatic int total_words();
      int t;
      t = 0;
      for (int s = 0; s < NUM_SEG; s++) t += int'(SEG_SIZE[s*ADDR_W +: ADDR_W]) / 4;
      return t;
   endfunction

   localparam int TOTAL_WORDS = total_words();
   localparam int IDX_W       = $clog2(TOTAL_WORDS + 1);

   function automatic logic [NUM_SEG*IDX_W-1:0] word_bases();
      logic [NUM_SEG*IDX_W-1:0] r;
      int sum;
      sum = 0;
      for (int s = 0; s < NUM_SEG; s++) begin
         r[s*IDX_W +: IDX_W] = IDX_W'(sum);
         sum += int'(SEG_SIZE[s*ADDR_W +: ADDR_W]) / 4;
      end
      return r;
   endfunction

   localparam logic [NUM_SEG*IDX_W-1:0] SEG_WBASE = word_bases();

   // R1: elaboration-time parameter checks
   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
      $error("burst_rom_target: DATA_W must be 32 or 64");
   end
   if (ADDR_W <= LEN_W) begin : g_bad_len
      $error("burst_rom_target: ADDR_W must exceed LEN_W");
   end
   for (genvar s = 0; s < NUM_SEG; s++) begin : g_chk_seg
      if (SEG_BASE[s*ADDR_W +: 2] != 2'b00 || SEG_SIZE[s*ADDR_W +: 2] != 2'b00 ||
          SEG_SIZE[s*ADDR_W +: ADDR_W] == '0) begin : g_bad_seg
         $error("burst_rom_target: segment base and size must be non-zero word multiples");
      end
   end

   rom_state_t        state;
   logic [IDX_W-1:0]  cur_idx;
   logic [LEN_W-1:0]  words_left;
   logic              dec_hit;
   logic [IDX_W-1:0]  dec_idx;
   logic [31:0]       word_lo;
   logic [31:0]       word_hi;
   logic              accept;
   logic              reject;
   logic              last_flit;

   rom_seg_decoder #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_SEG(NUM_SEG), .IDX_W(IDX_W),
      .SEG_BASE(SEG_BASE), .SEG_SIZE(SEG_SIZE), .SEG_WBASE(SEG_WBASE)
   ) dec_i (
      .addr(cmd_addr), .plen(cmd_plen), .hit(dec_hit), .idx(dec_idx)
   );

   rom_image #(
      .ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG), .IDX_W(IDX_W),
      .SEG_BASE(SEG_BASE), .SEG_SIZE(SEG_SIZE), .SEG_WBASE(SEG_WBASE),
      .ROM_SEED(ROM_SEED)
   ) img_i (
      .idx_a(cur_idx), .idx_b(cur_idx + IDX_W'(1)), .q_a(word_lo), .q_b(word_hi)
   );

   assign cmd_ack   = (state == ST_IDLE);
   assign accept    = cmd_val && cmd_ack;
   assign reject    = cmd_write || !dec_hit || (cmd_plen == '0);
   assign last_flit = (words_left <= LEN_W'(WPF));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cur_idx    <= '0;
         words_left <= '0;
         rsp_srcid  <= '0;
         rsp_trdid  <= '0;
         rsp_pktid  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               rsp_srcid  <= cmd_srcid;
               rsp_trdid  <= cmd_trdid;
               rsp_pktid  <= cmd_pktid;
               cur_idx    <= dec_idx;
               words_left <= cmd_plen >> 2;
               state      <= reject ? ST_ERR : ST_BURST;
            end
            ST_BURST: if (rsp_ack) begin
               if (last_flit) begin
                  state <= ST_IDLE;
               end else begin
                  cur_idx    <= cur_idx + IDX_W'(WPF);
                  words_left <= words_left - LEN_W'(WPF);
               end
            end
            ST_ERR: if (rsp_ack) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign rsp_val = (state != ST_IDLE);
   assign rsp_err = (state == ST_ERR);
   assign rsp_eop = rsp_err || ((state == ST_BURST) && last_flit);

   if (WPF == 1) begin : g_narrow
      assign rsp_data = (state == ST_BURST) ? word_lo : '0;
   end else begin : g_wide
      logic [31:0] upper;
      assign upper    = (words_left >= LEN_W'(2)) ? word_hi : 32'd0;
      assign rsp_data = (state == ST_BURST) ? {upper, word_lo} : '0;
   end

endmodule

// File: rtl/burst_rom_target_chk.sv
module burst_rom_target_chk #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8,
   parameter int SRC_W  = 4,
   parameter int TRD_W  = 4,
   parameter int PKT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_val,
   input logic              cmd_ack,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [LEN_W-1:0]  cmd_plen,
   input logic [SRC_W-1:0]  cmd_srcid,
   input logic              rsp_val,
   input logic              rsp_ack,
   input logic [DATA_W-1:0] rsp_data,
   input logic              rsp_eop,
   input logic              rsp_err,
   input logic [SRC_W-1:0]  rsp_srcid
);

   assert_ack_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ack |-> !rsp_val);

   assert_first_flit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_val && cmd_ack) |=> rsp_val);

   assert_eop_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_eop |-> rsp_val);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_val && !rsp_ack) |=> (rsp_val && $stable(rsp_data) && $stable(rsp_eop) &&
                                 $stable(rsp_err) && $stable(rsp_srcid)));

   assert_err_flit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_eop && rsp_data == '0));

   assert_srcid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_val && cmd_ack) |=> (rsp_srcid == $past(cmd_srcid)));

   assert_aligned_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_val |-> (cmd_addr[1:0] == 2'b00 && cmd_plen[1:0] == 2'b00));

endmodule

bind burst_rom_target burst_rom_target_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
   .SRC_W(SRC_W), .TRD_W(TRD_W), .PKT_W(PKT_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_val(cmd_val), .cmd_ack(cmd_ack),
   .cmd_addr(cmd_addr), .cmd_plen(cmd_plen), .cmd_srcid(cmd_srcid),
   .rsp_val(rsp_val), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
   .rsp_eop(rsp_eop), .rsp_err(rsp_err), .rsp_srcid(rsp_srcid)
);

// File: tb/burst_rom_target_tb_unit.sv
module burst_rom_target_tb_unit #(
   parameter int DW = 32
) (
   input logic clk,
   input logic rst_n
);

   typedef struct packed {
      logic [63:0] d;
      logic        eop;
      logic        err;
      logic [3:0]  s;
      logic [3:0]  t;
      logic [3:0]  p;
   } exp_t;

   logic          cmd_val = 1'b0;
   logic          cmd_ack;
   logic [31:0]   cmd_addr = '0;
   logic [7:0]    cmd_plen = '0;
   logic          cmd_write = 1'b0;
   logic [3:0]    cmd_srcid = '0, cmd_trdid = '0, cmd_pktid = '0;
   logic          rsp_val;
   logic          rsp_ack = 1'b0;
   logic [DW-1:0] rsp_data;
   logic          rsp_eop, rsp_err;
   logic [3:0]    rsp_srcid, rsp_trdid, rsp_pktid;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;
   int    cyc    = 0;
   bit    prev_stall = 1'b0;
   logic [DW-1:0] prev_data = '0;

   burst_rom_target #(.DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_val(cmd_val), .cmd_ack(cmd_ack), .cmd_addr(cmd_addr), .cmd_plen(cmd_plen),
      .cmd_write(cmd_write), .cmd_srcid(cmd_srcid), .cmd_trdid(cmd_trdid),
      .cmd_pktid(cmd_pktid), .rsp_val(rsp_val), .rsp_ack(rsp_ack),
      .rsp_data(rsp_data), .rsp_eop(rsp_eop), .rsp_err(rsp_err),
      .rsp_srcid(rsp_srcid), .rsp_trdid(rsp_trdid), .rsp_pktid(rsp_pktid)
   );

   // R10: word content model
   function automatic logic [31:0] rw(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s (DW=%0d): actual %h expected %h", tag, DW, act, expv);
      end
   endtask

   // driver: queue expected flits, then present the command until accepted
   task automatic send(input logic [31:0] a, input logic [7:0] pl, input bit wr,
                       input bit is_err, input logic [3:0] id, input string tag);
      exp_t e;
      int   nw;
      int   nf;
      nw = int'(pl) / 4;
      e.s = id; e.t = id + 4'd1; e.p = id + 4'd2;
      if (is_err) begin
         e.d = '0; e.eop = 1'b1; e.err = 1'b1;
         exp_q.push_back(e); tag_q.push_back(tag);
      end else begin
         nf = (DW == 32) ? nw : (nw + 1) / 2;
         for (int f = 0; f < nf; f++) begin
            e.err = 1'b0;
            e.eop = (f == nf - 1);
            if (DW == 32) e.d = {32'd0, rw(a + 32'(4*f))};
            else e.d = {((2*f + 1) < nw) ? rw(a + 32'(8*f + 4)) : 32'd0, rw(a + 32'(8*f))};
            exp_q.push_back(e); tag_q.push_back(tag);
         end
      end
      @(negedge clk);
      cmd_val = 1'b1; cmd_addr = a; cmd_plen = pl; cmd_write = wr;
      cmd_srcid = id; cmd_trdid = id + 4'd1; cmd_pktid = id + 4'd2;
      while (!cmd_ack) @(negedge clk);
      @(posedge clk);
      #1 cmd_val = 1'b0;
   endtask

   // backpressure pattern, changed just after each edge
   always @(posedge clk) begin
      cyc++;
      #1 rsp_ack = (cyc % 3 != 1) && (cyc % 7 != 3);
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_val) chk(!cmd_ack, "R2 cmd_ack low during response", 64'(cmd_ack), 64'd0);
         if (prev_stall) begin
            chk(rsp_val, "R7 valid held under stall", 64'(rsp_val), 64'd1);
            chk(rsp_data == prev_data, "R7 data held under stall", 64'(rsp_data), 64'(prev_data));
         end
         if (rsp_val && rsp_ack) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected response flit", 64'(rsp_data), 64'd0);
            end else begin
               exp_t  e;
               string tg;
               e  = exp_q.pop_front();
               tg = tag_q.pop_front();
               chk(64'(rsp_data) == e.d, {tg, " R10 data"}, 64'(rsp_data), e.d);
               chk(rsp_eop == e.eop, {tg, " R6 eop"}, 64'(rsp_eop), 64'(e.eop));
               chk(rsp_err == e.err, {tg, " R8 err flag"}, 64'(rsp_err), 64'(e.err));
               chk({rsp_srcid, rsp_trdid, rsp_pktid} == {e.s, e.t, e.p}, {tg, " R9 ids"},
                   64'({rsp_srcid, rsp_trdid, rsp_pktid}), 64'({e.s, e.t, e.p}));
            end
         end
         prev_stall = rsp_val && !rsp_ack;
         prev_data  = rsp_data;
      end
   end

   initial begin
      string rd;
      rd = (DW == 32) ? "R3" : "R4";
      wait (rst_n === 1'b1);
      @(negedge clk);
      chk(!rsp_val, "R2 reset rsp_val", 64'(rsp_val), 64'd0);
      chk(cmd_ack, "R2 reset cmd_ack", 64'(cmd_ack), 64'd1);
      send(32'h1000, 8'd16, 1'b0, 1'b0, 4'h1, rd);
      send(32'h1004, 8'd12, 1'b0, 1'b0, 4'h2, (DW == 32) ? "R3 odd" : "R5 odd");
      send(32'h8000, 8'd32, 1'b0, 1'b0, 4'h3, "R11 seg1 full");
      send(32'h1038, 8'd8,  1'b0, 1'b0, 4'h4, "R8 ends at segment end");
      send(32'h103C, 8'd8,  1'b0, 1'b1, 4'h5, "R8 crosses segment end");
      send(32'h2000, 8'd4,  1'b0, 1'b1, 4'h6, "R8 unmapped");
      send(32'h1000, 8'd8,  1'b1, 1'b1, 4'h7, "R8 write");
      send(32'h801C, 8'd4,  1'b0, 1'b0, 4'h8, (DW == 32) ? "R3 single" : "R5 single half");
      send(32'h1010, 8'd0,  1'b0, 1'b1, 4'h9, "R8 zero length");
      send(32'h0FFC, 8'd8,  1'b0, 1'b1, 4'hA, "R8 below base");
      send(32'h8008, 8'd20, 1'b0, 1'b0, 4'hB, (DW == 32) ? "R11 seg1" : "R5 R11 seg1 odd");
      send(32'h1020, 8'd32, 1'b0, 1'b0, 4'hC, rd);
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

endmodule

// File: tb/burst_rom_target_tb_top.sv
module burst_rom_target_tb_top;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   int   wd_fail = 0;

   always #4 clk = ~clk;  // 125 MHz

   burst_rom_target_tb_unit #(.DW(32)) u32 (.clk(clk), .rst_n(rst_n));
   burst_rom_target_tb_unit #(.DW(64)) u64 (.clk(clk), .rst_n(rst_n));

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!(u32.done && u64.done) && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!(u32.done && u64.done)) begin
         wd_fail = 1;
         $display("FAIL R2 watchdog expired: actual %0d cycles expected completion", cyc);
      end
      $display("End of test - %0d assertions evaluated, %0d failures",
               u32.n_chk + u64.n_chk + wd_fail, u32.n_fail + u64.n_fail + wd_fail);
      $finish;
   end

endmodule